// File: doc/BRIEF.md
# Dual-Mode Descriptor Submission Queue

This block is a first-in first-out store for 64-byte work descriptors. Each descriptor arrives as one wide write through a memory-mapped portal, in a single cycle. Stored descriptors go to a downstream arbiter over a valid/ready channel. Each descriptor leaves with an address-space identifier attached.

Before the queue is enabled, configuration selects one of two submission modes. In shared mode, several submitters may write to the portal. Every write gets a response one cycle later, saying either that the descriptor was taken or that the submitter must retry. In dedicated mode, a single owner writes to the portal and no response is returned. A write that finds the queue full is discarded and raises a sticky overflow flag. In shared mode the identifier comes from the request. In dedicated mode it comes from a value held in configuration.

The programmed capacity, mode and static identifier can be written only while the queue is disabled. Disabling the queue empties it.

Top module: `desc_wq`

## Requirements
- R1: After reset the queue is empty, `o_valid`, `rsp_valid`, `ovf_err` and `cfg_rej` are 0, and the configuration is dedicated mode with capacity `MAX_DEPTH` and static identifier 0.
- R2: In shared mode, an enabled portal write to a non-full queue is stored with the identifier on `p_pid`. In the next cycle `rsp_valid`=1 and `rsp_retry`=0.
- R3: In shared mode, a portal write that finds the queue full or disabled is not stored. In the next cycle `rsp_valid`=1 and `rsp_retry`=1.
- R4: In dedicated mode, no portal write produces `rsp_valid`. A stored entry carries the configured static identifier, and `p_pid` is ignored.
- R5: In dedicated mode, an enabled write to a full queue is dropped and sets `ovf_err`. The flag stays at 1 until `ovf_clr` is asserted. A write while disabled does not set it.
- R6: Descriptors leave in arrival order. While `o_valid`=1 and `o_ready`=0, `o_desc` and `o_pid` hold.
- R7: Occupancy `occ` never exceeds the programmed capacity. A queue holding that many entries counts as full.
- R8: A configuration write (`cfg_wr`) while `q_en`=1 is ignored and does not pulse `cfg_rej`.
- R9: A configuration write while disabled is rejected if any of these holds: it asks for shared mode while `grp_shared_busy`=1, it asks for capacity 0, or it asks for capacity above `MAX_DEPTH`. A rejected write pulses `cfg_rej` for one cycle and leaves the configuration unchanged.
- R10: In any cycle with `q_en`=0, `o_valid` is 0. On the next cycle `occ` is 0 and every stored entry is gone.
- R11: Fullness is judged on occupancy before the same cycle's output handshake. A write to a full queue in a cycle that also pops an entry is still refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| q_en | input | 1 | Queue enable; low flushes |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_shared_in | input | 1 | Requested mode, 1 = shared |
| cfg_depth_in | input | CNT_W | Requested capacity |
| cfg_pid_in | input | PID_W | Static identifier for dedicated mode |
| grp_shared_busy | input | 1 | Group already owns a shared queue |
| cfg_rej | output | 1 | Configuration write refused (one-cycle pulse) |
| p_valid | input | 1 | Portal write strobe |
| p_data | input | DESC_W | Descriptor payload |
| p_pid | input | PID_W | Identifier carried with the request |
| rsp_valid | output | 1 | Response valid (shared mode only) |
| rsp_retry | output | 1 | 1 = not taken, retry |
| ovf_err | output | 1 | Sticky dedicated-mode overflow |
| ovf_clr | input | 1 | Clears `ovf_err` |
| o_valid | output | 1 | Head descriptor available |
| o_ready | input | 1 | Downstream accepts head |
| o_desc | output | DESC_W | Head descriptor |
| o_pid | output | PID_W | Head identifier |
| occ | output | CNT_W | Current occupancy |

## Verification
The hardest case to reach is a write that arrives at a full queue in the same cycle as the output handshake frees a slot. The table first fills a three-entry shared queue, then presents a write and a ready together, expecting a retry and one entry fewer. The configuration rules need the bench to move back and forth between the enabled and disabled states. The bench shows that an ignored or rejected configuration had no effect only through later behaviour: writes still get no response, and an overflow still occurs at the old capacity.

// File: rtl/desc_wq.sv
module desc_wq #(
  parameter int MAX_DEPTH = 16,
  parameter int PID_W = 20,
  parameter int DESC_W = 512,
  localparam int CNT_W = $clog2(MAX_DEPTH + 1),
  localparam int PTR_W = $clog2(MAX_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_en,
  input  logic              cfg_wr,
  input  logic              cfg_shared_in,
  input  logic [CNT_W-1:0]  cfg_depth_in,
  input  logic [PID_W-1:0]  cfg_pid_in,
  input  logic              grp_shared_busy,
  output logic              cfg_rej,
  input  logic              p_valid,
  input  logic [DESC_W-1:0] p_data,
  input  logic [PID_W-1:0]  p_pid,
  output logic              rsp_valid,
  output logic              rsp_retry,
  output logic              ovf_err,
  input  logic              ovf_clr,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [DESC_W-1:0] o_desc,
  output logic [PID_W-1:0]  o_pid,
  output logic [CNT_W-1:0]  occ
);

  logic              shared_r;
  logic [CNT_W-1:0]  depth_r;
  logic [PID_W-1:0]  pid_r;
  logic [CNT_W-1:0]  count;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [DESC_W-1:0] mem_d [MAX_DEPTH];
  logic [PID_W-1:0]  mem_p [MAX_DEPTH];

  wire cfg_ok  = cfg_wr && !q_en;
  wire cfg_bad = (cfg_shared_in && grp_shared_busy) || (cfg_depth_in == '0) ||
                 (cfg_depth_in > CNT_W'(MAX_DEPTH));
  wire full    = count >= depth_r;
  wire push    = p_valid && q_en && !full;
  wire pop     = o_valid && o_ready;
  wire drop    = p_valid && q_en && full && !shared_r;

  wire [PID_W-1:0] ins_pid = shared_r ? p_pid : pid_r;

  assign o_valid = q_en && (count != '0);
  assign o_desc  = mem_d[rd_ptr];
  assign o_pid   = mem_p[rd_ptr];
  assign occ     = count;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(MAX_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shared_r <= 1'b0;
      depth_r  <= CNT_W'(MAX_DEPTH);
      pid_r    <= '0;
      cfg_rej  <= 1'b0;
    end else begin
      cfg_rej <= cfg_ok && cfg_bad;
      if (cfg_ok && !cfg_bad) begin
        shared_r <= cfg_shared_in;
        depth_r  <= cfg_depth_in;
        pid_r    <= cfg_pid_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (!q_en) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_d[wr_ptr] <= p_data;
      mem_p[wr_ptr] <= ins_pid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_retry <= 1'b0;
      ovf_err   <= 1'b0;
    end else begin
      rsp_valid <= p_valid && shared_r;
      rsp_retry <= p_valid && shared_r && !push;
      if (drop)         ovf_err <= 1'b1;
      else if (ovf_clr) ovf_err <= 1'b0;
    end
  end

endmodule

// File: rtl/desc_wq_chk.sv
module desc_wq_chk #(
  parameter int CNT_W = 5,
  parameter int PID_W = 20,
  parameter int DESC_W = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              q_en,
  input logic              p_valid,
  input logic              shared_r,
  input logic              full,
  input logic [CNT_W-1:0]  depth_r,
  input logic [CNT_W-1:0]  occ,
  input logic              rsp_valid,
  input logic              rsp_retry,
  input logic              ovf_err,
  input logic              ovf_clr,
  input logic              o_valid,
  input logic              o_ready,
  input logic [DESC_W-1:0] o_desc,
  input logic [PID_W-1:0]  o_pid
);

  // R7
  occ_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) occ <= depth_r);

  // R2
  shared_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid && shared_r |=> rsp_valid);

  // R3
  shared_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid && shared_r && q_en && full |=> rsp_valid && rsp_retry);

  // R4
  posted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_valid && shared_r) |=> !rsp_valid);

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err && !ovf_clr |=> ovf_err);

  // R6
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready && q_en |=> $stable(o_desc) && $stable(o_pid));

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_en |=> occ == '0);

  // R10
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !q_en |-> !o_valid);

endmodule

bind desc_wq desc_wq_chk #(.CNT_W(CNT_W), .PID_W(PID_W), .DESC_W(DESC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_en(q_en), .p_valid(p_valid), .shared_r(shared_r),
  .full(full), .depth_r(depth_r), .occ(occ), .rsp_valid(rsp_valid),
  .rsp_retry(rsp_retry), .ovf_err(ovf_err), .ovf_clr(ovf_clr), .o_valid(o_valid),
  .o_ready(o_ready), .o_desc(o_desc), .o_pid(o_pid)
);

// File: tb/sim_desc_wq.sv
module sim_desc_wq;
  localparam int CLK_P = 10;
  localparam int MAXD = 16;
  localparam int PW = 20;
  localparam int DW = 512;
  localparam int CW = $clog2(MAXD + 1);

  logic clk = 0, rst_n = 0;
  logic q_en = 0, cfg_wr = 0, cfg_shared_in = 0, grp_shared_busy = 0;
  logic [CW-1:0] cfg_depth_in = '0;
  logic [PW-1:0] cfg_pid_in = '0, p_pid = '0, o_pid;
  logic cfg_rej, p_valid = 0, rsp_valid, rsp_retry, ovf_err, ovf_clr = 0;
  logic o_valid, o_ready = 0;
  logic [DW-1:0] p_data = '0, o_desc;
  logic [CW-1:0] occ;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  desc_wq u0 (.*);

  // push, pop, expected retry, expected occupancy
  localparam logic [7:0] VEC [10] = '{
    8'b100_00001, 8'b100_00010, 8'b100_00011, 8'b101_00011, 8'b111_00010,
    8'b010_00001, 8'b110_00001, 8'b010_00000, 8'b010_00000, 8'b100_00001
  };

  int mseed [16];
  int mpid [16];
  int mh = 0, mt = 0, mc = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input int seed, input int pid);
    p_valid = 1;
    p_data = {16{32'(seed)}};
    p_pid = PW'(pid);
  endtask

  task automatic setcfg(input logic sh, input int d, input int pid);
    q_en = 0;
    cfg_wr = 1;
    cfg_shared_in = sh;
    cfg_depth_in = CW'(d);
    cfg_pid_in = PW'(pid);
    cyc();
    cfg_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 occ", 64'(occ), 0);
    chk("R1 o_valid", 64'(o_valid), 0);
    chk("R1 rsp_valid", 64'(rsp_valid), 0);
    chk("R1 ovf_err", 64'(ovf_err), 0);
    chk("R1 cfg_rej", 64'(cfg_rej), 0);
    q_en = 1;
    put(32'h11, 32'h777);
    cyc();
    p_valid = 0;
    chk("R1 default dedicated no rsp", 64'(rsp_valid), 0);
    chk("R1 default pid", 64'(o_pid), 0);

    // dedicated, capacity 2
    setcfg(0, 2, 32'hABC);
    chk("R1 flush before cfg", 64'(occ), 0);
    q_en = 1;
    put(32'hA0, 32'h555);
    cyc();
    chk("R4 no rsp", 64'(rsp_valid), 0);
    chk("R4 static pid", 64'(o_pid), 64'h0ABC);
    put(32'hA1, 32'h555);
    cyc();
    put(32'hA2, 32'h555);
    cyc();
    p_valid = 0;
    chk("R7 occ capped", 64'(occ), 2);
    chk("R5 ovf set", 64'(ovf_err), 1);
    cyc();
    cyc();
    chk("R6 head held", 64'(o_desc[31:0]), 64'hA0);
    chk("R5 ovf sticky", 64'(ovf_err), 1);
    ovf_clr = 1;
    cyc();
    ovf_clr = 0;
    chk("R5 ovf cleared", 64'(ovf_err), 0);

    // configuration while enabled is ignored
    cfg_wr = 1;
    cfg_shared_in = 1;
    cfg_depth_in = 5;
    cyc();
    cfg_wr = 0;
    chk("R8 no reject pulse", 64'(cfg_rej), 0);
    o_ready = 1;
    cyc();
    o_ready = 0;
    chk("R6 order second", 64'(o_desc[31:0]), 64'hA1);
    put(32'hA3, 32'h1);
    cyc();
    chk("R8 still dedicated", 64'(rsp_valid), 0);
    put(32'hA4, 32'h1);
    cyc();
    p_valid = 0;
    chk("R8 old capacity kept", 64'(ovf_err), 1);
    ovf_clr = 1;
    cyc();
    ovf_clr = 0;

    // flush and disabled writes
    q_en = 0;
    #1;
    chk("R10 o_valid gated", 64'(o_valid), 0);
    cyc();
    chk("R10 flushed", 64'(occ), 0);
    put(32'hB0, 32'h1);
    cyc();
    p_valid = 0;
    chk("R5 disabled write no ovf", 64'(ovf_err), 0);
    chk("R10 disabled write not stored", 64'(occ), 0);

    // rejected configurations
    grp_shared_busy = 1;
    setcfg(1, 4, 32'h9);
    chk("R9 shared rejected", 64'(cfg_rej), 1);
    cyc();
    chk("R9 pulse one cycle", 64'(cfg_rej), 0);
    setcfg(0, 0, 32'h9);
    chk("R9 zero capacity", 64'(cfg_rej), 1);
    setcfg(0, MAXD + 1, 32'h9);
    chk("R9 oversize capacity", 64'(cfg_rej), 1);
    q_en = 1;
    put(32'hC0, 32'h1);
    cyc();
    p_valid = 0;
    chk("R9 config unchanged mode", 64'(rsp_valid), 0);
    chk("R9 config unchanged pid", 64'(o_pid), 64'h0ABC);

    // shared, capacity 3, table driven
    grp_shared_busy = 0;
    setcfg(1, 3, 0);
    chk("R9 accepted", 64'(cfg_rej), 0);
    q_en = 1;
    cyc();
    for (int i = 0; i < 10; i++) begin
      logic [7:0] row;
      bit acc, pp;
      row = VEC[i];
      p_valid = row[7];
      p_data = {16{32'(i + 32'h1000)}};
      p_pid = PW'(32'h100 + i);
      o_ready = row[6];
      #1;
      pp = row[6] && (mc > 0);
      if (pp) begin
        chk("R6 order desc", 64'(o_desc[31:0]), 64'(mseed[mh]));
        chk("R2 request pid", 64'(o_pid), 64'(mpid[mh]));
      end
      acc = row[7] && (mc < 3);
      cyc();
      if (pp) begin
        mh = (mh + 1) % 16;
        mc--;
      end
      if (acc) begin
        mseed[mt] = i + 32'h1000;
        mpid[mt] = 32'h100 + i;
        mt = (mt + 1) % 16;
        mc++;
      end
      chk("R2 rsp_valid", 64'(rsp_valid), 64'(row[7]));
      if (row[7]) chk(i == 4 ? "R11 full at pop" : "R3 retry flag", 64'(rsp_retry), 64'(row[5]));
      chk("R7 occupancy", 64'(occ), 64'(row[4:0]));
    end
    p_valid = 0;
    o_ready = 0;

    q_en = 0;
    put(32'hD0, 32'h1);
    cyc();
    p_valid = 0;
    chk("R3 disabled shared retry", 64'(rsp_retry), 1);
    chk("R10 empty", 64'(occ), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule